// File: doc/BRIEF.md
# Descending Link-Chain Initializer

This engine prepares an empty, backward-linked table in word-addressed memory. A single start pulse supplies a base address and an entry count. From that base the engine walks toward lower memory one word (4 bytes) at a time. Each word it stores holds the address of the word just below it. The lowest word it reaches gets a fixed end-of-chain code instead of a link. Software can later follow the chain from the top entry down to the marker.

Stores leave through a single word-wide write port with a valid/ready handshake. A store completes only in a cycle where both valid and ready are high. While ready is low, the pending store is held unchanged. When the final store has been accepted, the engine gives a one-cycle done pulse and is idle again in that same cycle. It can therefore take a new start pulse while done is high.

Top module: `oclr_engine`

## Requirements
- R1: While reset is asserted (rst_n low) and in the first cycle after it, mem_wr_valid, busy and done are all 0.
- R2: A start pulse sampled while idle makes the first store, presented in the next cycle, target the base address reduced to its low AW bits (AW = 21, that is base AND 0x1FFFFF).
- R3: After each accepted store that is not the last, the next store address is the previous one minus 4, modulo 2^AW.
- R4: Every store other than the last carries as data its own address minus 4, modulo 2^AW, zero-extended to 32 bits.
- R5: The last store, at the lowest address, carries the data 0x00FFFFFF.
- R6: For a count N ≥ 1 exactly N stores are accepted per run. A count of 0 gives exactly one store, which is the end-of-chain store.
- R7: While mem_wr_valid is high and mem_wr_ready is low, address and data stay unchanged and nothing advances.
- R8: done is high for exactly one cycle. That cycle is the one right after the final accepted store, and busy is already 0 in it.
- R9: A start pulse while busy is ignored. The run in progress keeps its address sequence and its count.
- R10: A start pulse sampled in the cycle where done is high is accepted, and a new run begins in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start request, sampled when idle |
| base_addr | input | 32 | Top-of-chain address; only the low AW bits are used |
| word_count | input | 32 | Number of entries to write (0 is handled as 1) |
| mem_wr_valid | output | 1 | Store request |
| mem_wr_addr | output | 21 | Store byte address |
| mem_wr_data | output | 32 | Store data: a link or the end-of-chain code |
| mem_wr_ready | input | 1 | Memory accepts the store in this cycle |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two functions can land in the same cycle: completion of one run and acceptance of the next. The bench waits until it sees done high. In that same cycle it raises start with a new base address. It then checks that the next cycle shows busy and the new base as the first store address. The bench also overlaps a start request with a stalled store in the middle of a run. A behavioural model compared every cycle judges that case: the address must not move and the write count must stay what it was.

// File: rtl/oclr_pkg.sv
package oclr_pkg;

  typedef enum logic {ST_IDLE, ST_RUN} oclr_state_e;

  // Mask keeping the low aw bits of a 32-bit address.
  function automatic logic [31:0] addr_mask(input int unsigned aw);
    if (aw >= 32) return '1;
    return (32'h1 << aw) - 32'h1;
  endfunction

  // Start address as seen by the engine.
  function automatic logic [31:0] masked_base(input logic [31:0] b, input int unsigned aw);
    return b & addr_mask(aw);
  endfunction

  // Link value stored at address a: the entry one step below, wrapped to aw bits.
  function automatic logic [31:0] link_word(input logic [31:0] a, input int unsigned aw,
                                            input int unsigned step);
    return (a - 32'(step)) & addr_mask(aw);
  endfunction

endpackage

// File: rtl/oclr_addr_ctr.sv
module oclr_addr_ctr #(
  parameter int unsigned AW   = 21,
  parameter int unsigned STEP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          advance,
  output logic [AW-1:0] addr
);
  localparam logic [AW-1:0] STEP_V = AW'(STEP);

  always_ff @(posedge clk) begin
    if (!rst_n)       addr <= '0;
    else if (load)    addr <= load_val;
    else if (advance) addr <= addr - STEP_V;
  end

  // R3: each advance moves exactly one step down
  a_r3_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !load) |=> addr == $past(addr) - STEP_V);
endmodule

// File: rtl/oclr_len_ctr.sv
module oclr_len_ctr #(
  parameter int unsigned CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_cnt,
  input  logic          advance,
  output logic          last
);
  logic [CW-1:0] remaining;
  logic [CW-1:0] eff_cnt;

  // A zero count behaves as a single entry.
  assign eff_cnt = (load_cnt == '0) ? CW'(1) : load_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)       remaining <= '0;
    else if (load)    remaining <= eff_cnt;
    else if (advance) remaining <= remaining - CW'(1);
  end

  assign last = (remaining == CW'(1));

  // R6: the counter never advances from zero
  a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    advance |-> remaining != '0);
endmodule

// File: rtl/oclr_engine.sv
module oclr_engine #(
  parameter int unsigned   AW   = 21,
  parameter int unsigned   CW   = 32,
  parameter int unsigned   DW   = 32,
  parameter int unsigned   STEP = 4,
  parameter logic [DW-1:0] TERM = DW'(32'h00FF_FFFF)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [31:0]   base_addr,
  input  logic [CW-1:0] word_count,
  output logic          mem_wr_valid,
  output logic [AW-1:0] mem_wr_addr,
  output logic [DW-1:0] mem_wr_data,
  input  logic          mem_wr_ready,
  output logic          busy,
  output logic          done
);
  import oclr_pkg::*;

  oclr_state_e state;
  logic start_accept;
  logic fire;
  logic last_beat;
  logic final_fire;
  logic [AW-1:0] cur_addr;
  logic [AW-1:0] start_addr;

  assign start_accept = start && (state == ST_IDLE);
  assign fire         = mem_wr_valid && mem_wr_ready;
  assign final_fire   = fire && last_beat;
  assign start_addr   = AW'(masked_base(base_addr, AW));

  oclr_addr_ctr #(.AW(AW), .STEP(STEP)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(start_accept), .load_val(start_addr),
    .advance(fire && !last_beat), .addr(cur_addr));

  oclr_len_ctr #(.CW(CW)) u_len (
    .clk(clk), .rst_n(rst_n), .load(start_accept), .load_cnt(word_count),
    .advance(fire), .last(last_beat));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      done <= final_fire;
      unique case (state)
        ST_IDLE: if (start_accept) state <= ST_RUN;
        ST_RUN:  if (final_fire)   state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign mem_wr_valid = (state == ST_RUN);
  assign busy         = (state == ST_RUN);
  assign mem_wr_addr  = cur_addr;
  assign mem_wr_data  = last_beat ? TERM : DW'(link_word(32'(cur_addr), AW, STEP));

  // R2: the first store targets the masked base
  a_r2_first_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> mem_wr_valid && mem_wr_addr == AW'($past(base_addr)));
  // R7: a stalled store is held
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && !mem_wr_ready) |=>
      mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data));
  // R8: done lasts one cycle
  a_r8_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8, R5: done follows an accepted end-of-chain store, with the engine idle
  a_r8_after_final: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(mem_wr_valid && mem_wr_ready) && $past(mem_wr_data) == TERM);
  // R9: start during a stalled store moves nothing
  a_r9_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !mem_wr_ready) |=> busy && $stable(mem_wr_addr));
endmodule

// File: tb/oclr_engine_test.sv
module oclr_engine_test;
  localparam int unsigned AW   = 21;
  localparam int unsigned MASK = 32'h001F_FFFF;
  localparam int unsigned TERM = 32'h00FF_FFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [31:0] base_addr = '0;
  logic [31:0] word_count = '0;
  logic mem_wr_ready = 1'b0;
  logic mem_wr_valid, busy, done;
  logic [AW-1:0] mem_wr_addr;
  logic [31:0] mem_wr_data;

  int checks = 0;
  int errors = 0;
  int ready_mode = 0;   // 0 always ready, 1 random, 2 held low
  int dut_writes = 0;

  always #5 clk = ~clk;

  oclr_engine uut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .word_count(word_count), .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .mem_wr_ready(mem_wr_ready), .busy(busy), .done(done));

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Behavioural reference model, stepped on every rising edge.
  bit m_busy = 0, m_done = 0, m_first = 0;
  longint unsigned m_addr = 0, m_left = 0;

  always @(posedge clk) begin
    if (mem_wr_valid && mem_wr_ready) dut_writes++;
    m_done = 0;
    if (!rst_n) begin
      m_busy = 0;
    end else if (m_busy) begin
      if (mem_wr_ready) begin
        if (m_left == 1) begin m_busy = 0; m_done = 1; end
        else begin m_addr = (m_addr - 4) & MASK; m_left--; m_first = 0; end
      end
    end else if (start) begin
      m_busy = 1; m_first = 1;
      m_addr = base_addr & MASK;
      m_left = (word_count == 0) ? 1 : word_count;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(mem_wr_valid == m_busy, "R6", "valid", mem_wr_valid, m_busy);
      chk(busy == m_busy, "R8", "busy", busy, m_busy);
      chk(done == m_done, "R8", "done", done, m_done);
      if (m_busy) begin
        chk(mem_wr_addr == m_addr, m_first ? "R2" : "R3", "addr", mem_wr_addr, m_addr);
        if (m_left == 1) chk(mem_wr_data == TERM, "R5", "data", mem_wr_data, TERM);
        else chk(mem_wr_data == ((m_addr - 4) & MASK), "R4", "data", mem_wr_data,
                 (m_addr - 4) & MASK);
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      case (ready_mode)
        0: mem_wr_ready = 1'b1;
        1: mem_wr_ready = 1'($urandom_range(0, 1));
        default: mem_wr_ready = 1'b0;
      endcase
    end
  end

  task automatic launch(input logic [31:0] b, input logic [31:0] n);
    @(negedge clk);
    dut_writes = 0;
    base_addr = b; word_count = n; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 4000; i++) begin
      if (done) return;
      @(negedge clk);
    end
  endtask

  task automatic run_and_count(input logic [31:0] b, input logic [31:0] n,
                               input int exp_n);
    launch(b, n);
    wait_done();
    chk(dut_writes == exp_n, "R6", "store count", dut_writes, exp_n);
    @(negedge clk);
  endtask

  bit finished = 0;

  initial begin
    #1_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!mem_wr_valid && !busy && !done, "R1", "reset outputs",
        {mem_wr_valid, busy, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!mem_wr_valid && !busy && !done, "R1", "after reset",
        {mem_wr_valid, busy, done}, 0);

    ready_mode = 0;
    run_and_count(32'h8012_3450, 5, 5);   // R2 masking, R4 links
    run_and_count(32'h0000_1000, 1, 1);   // R5 single terminator
    run_and_count(32'h0000_2000, 0, 1);   // R6 zero count
    ready_mode = 1;
    run_and_count(32'h0000_0008, 4, 4);   // R3 wrap below zero
    run_and_count(32'hFFFF_FFFC, 20, 20);

    // R7 and R9: stall, then request a start mid-run
    ready_mode = 2;
    launch(32'h0000_4000, 3);
    repeat (4) @(negedge clk);
    chk(mem_wr_addr == 21'h4000, "R7", "stalled addr", mem_wr_addr, 32'h4000);
    chk(dut_writes == 0, "R7", "stalled stores", dut_writes, 0);
    base_addr = 32'h0000_9000; word_count = 9; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk(mem_wr_addr == 21'h4000, "R9", "addr after ignored start", mem_wr_addr, 32'h4000);
    ready_mode = 0;
    wait_done();
    chk(dut_writes == 3, "R9", "count kept", dut_writes, 3);

    // R10: start in the done cycle
    launch(32'h0000_5000, 2);
    wait_done();
    chk(done == 1'b1, "R10", "done seen", done, 1);
    base_addr = 32'h0000_6000; word_count = 2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R10", "busy after back-to-back", busy, 1);
    chk(mem_wr_addr == 21'h6000, "R10", "new base", mem_wr_addr, 32'h6000);
    wait_done();
    repeat (2) @(negedge clk);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule